// File: doc/BRIEF.md
# Dual Stack Pointer Memory Sequencer

This block owns two 8-bit stack pointers for a small byte-oriented processor and turns stack operation strobes into byte-wide accesses on a data RAM. It also holds the RAM model. The program stack saves and restores return state. A two-byte frame holds a 14-bit program counter plus the carry and zero flags. Frames are saved on a subroutine call or an interrupt entry, and they are restored on a subroutine return or an interrupt return. The program stack grows upward and its pointer moves after each access.

The data stack holds single bytes. A push moves its pointer down before it writes, and a pop reads before it moves the pointer up. A push from pointer zero therefore wraps to the top of the RAM. Either pointer can also be set from the accumulator value. The data pointer is exchanged with it, so the old value comes back on the accumulator output.

An operation is accepted when `op_valid` is high and the block is idle. Each RAM access takes one cycle, with `busy` high throughout. `done` is high in the last access cycle, and results show on the outputs after that cycle's clock edge.

Top module: `dual_stack_seq`

## Requirements
- R1: After reset both pointers, the restored program counter, both restored flags, the interrupt-enable output and the accumulator output are zero, and `busy` is low.
- R2: A call (`op_code` 0) takes two busy cycles. The first cycle writes PC[7:0] at the program pointer. The second writes {C, Z, PC[13:8]} at the incremented pointer, with C at bit 7 and Z at bit 6. The pointer ends two higher.
- R3: An interrupt entry (`op_code` 1) writes the same two-byte frame as R2 and clears `int_en`.
- R4: An interrupt return (`op_code` 3) takes two cycles. It reads the second frame byte at program pointer minus one, then the first byte at pointer minus two. It restores PC, C and Z, leaves the pointer two lower and sets `int_en`.
- R5: A subroutine return (`op_code` 2) moves the pointer and restores PC in the same way as R4, but leaves C, Z and `int_en` unchanged.
- R6: A push (`op_code` 4) takes one cycle. It writes the accumulator at data pointer minus one, and the pointer ends one lower.
- R7: A push with the data pointer at 0 writes address 0xFF and leaves the pointer at 0xFF.
- R8: A pop (`op_code` 5) takes one cycle. It reads the byte at the data pointer onto `acc_out` and leaves the pointer one higher.
- R9: A program pointer load (`op_code` 6) takes one cycle, sets the program pointer to the accumulator value and writes no RAM.
- R10: A data pointer swap (`op_code` 7) takes one cycle. It sets the data pointer to the accumulator value, returns the old data pointer on `acc_out` and writes no RAM.
- R11: `op_valid` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 3 | Operation select (see requirements) |
| pc_in | input | 14 | Program counter to save |
| c_in | input | 1 | Carry flag to save |
| z_in | input | 1 | Zero flag to save |
| acc_in | input | 8 | Accumulator value for push or pointer commands |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last access cycle of an operation |
| pc_out | output | 14 | Restored program counter |
| c_out | output | 1 | Restored carry flag |
| z_out | output | 1 | Restored zero flag |
| int_en | output | 1 | Interrupt enable state |
| acc_out | output | 8 | Popped byte or old data pointer |
| psp | output | 8 | Program stack pointer |
| dsp | output | 8 | Data stack pointer |
| ram_addr | output | 8 | RAM address this cycle |
| ram_we | output | 1 | RAM write strobe |
| ram_wdata | output | 8 | RAM write data |

## Verification
The assertions assume that `op_code` is stable and known while `op_valid` is high. They also assume that reset is applied before the first operation, so every pointer step they compare starts from a value written after reset. The stimulus changes inputs only at falling edges. It holds `op_valid` for exactly one idle cycle per operation, except where it deliberately keeps the strobe high with a different code during a busy cycle to probe R11. Each return it issues pops a frame that it saved earlier, so the restored values are always defined.

// File: rtl/dual_stack_seq.sv
module dual_stack_seq #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [2*DW-3:0]   pc_in,
  input  logic              c_in,
  input  logic              z_in,
  input  logic [DW-1:0]     acc_in,
  output logic              busy,
  output logic              done,
  output logic [2*DW-3:0]   pc_out,
  output logic              c_out,
  output logic              z_out,
  output logic              int_en,
  output logic [DW-1:0]     acc_out,
  output logic [AW-1:0]     psp,
  output logic [AW-1:0]     dsp,
  output logic [AW-1:0]     ram_addr,
  output logic              ram_we,
  output logic [DW-1:0]     ram_wdata
);
  localparam int PCW   = 2*DW-2;
  localparam int DEPTH = 1 << AW;

  typedef enum logic [2:0] {
    OP_CALL, OP_INTR, OP_RET, OP_RETI, OP_PUSH, OP_POP, OP_LDPSP, OP_XDSP
  } op_t;

  op_t            op_q;
  logic [1:0]     step;
  logic [PCW-1:0] pc_q;
  logic           c_q, z_q;
  logic [DW-1:0]  acc_q, hi_q, rdata;
  logic [DW-1:0]  mem [DEPTH];
  logic           two_step;

  assign two_step = (op_q == OP_CALL) || (op_q == OP_INTR) ||
                    (op_q == OP_RET)  || (op_q == OP_RETI);
  assign busy  = (step != 2'd0);
  assign done  = (step == 2'd2) || (step == 2'd1 && !two_step);
  assign rdata = mem[ram_addr];

  always_comb begin
    ram_addr  = psp;
    ram_we    = 1'b0;
    ram_wdata = acc_q;
    case (op_q)
      OP_CALL, OP_INTR: begin
        ram_we    = busy;
        ram_wdata = (step == 2'd2) ? {c_q, z_q, pc_q[PCW-1:DW]} : pc_q[DW-1:0];
      end
      OP_RET, OP_RETI: ram_addr = psp - 1'b1;
      OP_PUSH: begin
        ram_we   = busy;
        ram_addr = dsp - 1'b1;
      end
      OP_POP:  ram_addr = dsp;
      default: ram_addr = psp;
    endcase
  end

  always_ff @(posedge clk)
    if (ram_we) mem[ram_addr] <= ram_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q    <= OP_CALL;
      step    <= 2'd0;
      pc_q    <= '0;
      c_q     <= 1'b0;
      z_q     <= 1'b0;
      acc_q   <= '0;
      hi_q    <= '0;
      pc_out  <= '0;
      c_out   <= 1'b0;
      z_out   <= 1'b0;
      int_en  <= 1'b0;
      acc_out <= '0;
      psp     <= '0;
      dsp     <= '0;
    end else if (!busy) begin
      if (op_valid) begin
        op_q  <= op_t'(op_code);
        pc_q  <= pc_in;
        c_q   <= c_in;
        z_q   <= z_in;
        acc_q <= acc_in;
        step  <= 2'd1;
        if (op_t'(op_code) == OP_INTR) int_en <= 1'b0;
      end
    end else begin
      step <= done ? 2'd0 : 2'd2;
      case (op_q)
        OP_CALL, OP_INTR: psp <= psp + 1'b1;
        OP_RET, OP_RETI: begin
          psp <= psp - 1'b1;
          if (step == 2'd1) hi_q <= rdata;
          else begin
            pc_out <= {hi_q[DW-3:0], rdata};
            if (op_q == OP_RETI) begin
              c_out  <= hi_q[DW-1];
              z_out  <= hi_q[DW-2];
              int_en <= 1'b1;
            end
          end
        end
        OP_PUSH: dsp <= dsp - 1'b1;
        OP_POP: begin
          dsp     <= dsp + 1'b1;
          acc_out <= rdata;
        end
        OP_LDPSP: psp <= acc_q;
        OP_XDSP: begin
          dsp     <= acc_q;
          acc_out <= dsp;
        end
      endcase
    end
  end

  assert_done_in_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  assert_hold_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy && $stable(op_q)));
  assert_frame_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (op_q == OP_CALL || op_q == OP_INTR)) |=> psp == $past(psp) + 1'b1);
  assert_intr_masks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q == OP_INTR) |-> !int_en);
  assert_reti_enables_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_RETI) |=> int_en);
  assert_ret_keeps_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_RET) |=> ($stable(c_out) && $stable(z_out) && $stable(int_en)));
  assert_push_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_PUSH) |=> dsp == $past(dsp) - 1'b1);
  assert_push_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_PUSH && dsp == '0) |=> dsp == '1);
  assert_pop_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_POP) |=> dsp == $past(dsp) + 1'b1);
  assert_ptr_cmd_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (op_q == OP_LDPSP || op_q == OP_XDSP)) |-> !ram_we);
endmodule

// File: tb/sim_dual_stack_seq.sv
`timescale 1ns/1ps
module sim_dual_stack_seq;
  logic clk = 1'b0, rst_n = 1'b0, op_valid = 1'b0;
  logic [2:0] op_code = '0;
  logic [13:0] pc_in = '0;
  logic c_in = 1'b0, z_in = 1'b0;
  logic [7:0] acc_in = '0;
  logic busy, done, c_out, z_out, int_en, ram_we;
  logic [13:0] pc_out;
  logic [7:0] acc_out, psp, dsp, ram_addr, ram_wdata;

  dual_stack_seq u0 (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  int m_mem [256];
  int m_psp = 0, m_dsp = 0, m_pc = 0, m_c = 0, m_z = 0, m_ie = 0, m_acc = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic check_state(string req);
    chk({req, " busy idle"}, busy, 0);
    chk({req, " psp"}, psp, m_psp);
    chk({req, " dsp"}, dsp, m_dsp);
    chk({req, " pc_out"}, pc_out, m_pc);
    chk({req, " c_out"}, c_out, m_c);
    chk({req, " z_out"}, z_out, m_z);
    chk({req, " int_en"}, int_en, m_ie);
    chk({req, " acc_out"}, acc_out, m_acc);
  endtask

  task automatic run(string req, int op, int pc, int c, int z, int acc, bit inject);
    int n, ea[2], ew[2], ed[2], hi, lo;
    n = (op < 4) ? 2 : 1;
    ew[0] = 0; ew[1] = 0; ed[0] = 0; ed[1] = 0; ea[0] = 0; ea[1] = 0;
    case (op)
      0, 1: begin
        ea[0] = m_psp; ew[0] = 1; ed[0] = pc & 255;
        ea[1] = (m_psp + 1) & 255; ew[1] = 1; ed[1] = (c << 7) | (z << 6) | (pc >> 8);
      end
      2, 3: begin ea[0] = (m_psp - 1) & 255; ea[1] = (m_psp - 2) & 255; end
      4: begin ea[0] = (m_dsp - 1) & 255; ew[0] = 1; ed[0] = acc; end
      5: ea[0] = m_dsp;
      default: ;
    endcase
    @(negedge clk);
    op_code = op[2:0]; pc_in = pc[13:0]; c_in = c[0]; z_in = z[0]; acc_in = acc[7:0];
    op_valid = 1'b1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (k == 0 && inject && n > 1) op_code = 3'd4;
      else op_valid = 1'b0;
      chk({req, " busy"}, busy, 1);
      chk({req, " done"}, done, (k == n - 1));
      chk({req, " ram_we"}, ram_we, ew[k]);
      if (op < 6) chk({req, " ram_addr"}, ram_addr, ea[k]);
      if (ew[k]) chk({req, " ram_wdata"}, ram_wdata, ed[k]);
    end
    op_valid = 1'b0;
    case (op)
      0, 1: begin
        m_mem[m_psp] = ed[0]; m_mem[(m_psp + 1) & 255] = ed[1];
        m_psp = (m_psp + 2) & 255;
        if (op == 1) m_ie = 0;
      end
      2, 3: begin
        hi = m_mem[(m_psp - 1) & 255]; lo = m_mem[(m_psp - 2) & 255];
        m_pc = ((hi & 63) << 8) | lo;
        if (op == 3) begin m_c = (hi >> 7) & 1; m_z = (hi >> 6) & 1; m_ie = 1; end
        m_psp = (m_psp - 2) & 255;
      end
      4: begin m_dsp = (m_dsp - 1) & 255; m_mem[m_dsp] = acc; end
      5: begin m_acc = m_mem[m_dsp]; m_dsp = (m_dsp + 1) & 255; end
      6: m_psp = acc & 255;
      default: begin m_acc = m_dsp; m_dsp = acc & 255; end
    endcase
    @(negedge clk);
    check_state(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R11 actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1 reset");
    run("R7 push at zero", 4, 0, 0, 0, 8'hA5, 0);
    run("R8 pop", 5, 0, 0, 0, 0, 0);
    run("R2 call", 0, 14'h02A5, 1, 0, 0, 0);
    run("R3 R11 interrupt entry with extra strobe", 1, 14'h3FFF, 0, 1, 0, 1);
    run("R4 reti", 3, 0, 0, 0, 0, 0);
    run("R5 ret", 2, 0, 0, 0, 0, 0);
    run("R3 interrupt clears enable", 1, 14'h1234, 1, 1, 0, 0);
    run("R4 reti sets enable", 3, 0, 0, 0, 0, 0);
    run("R9 load psp", 6, 0, 0, 0, 8'h40, 0);
    run("R2 call high", 0, 14'h0100, 0, 0, 0, 1);
    run("R5 ret high", 2, 0, 0, 0, 0, 0);
    run("R10 swap dsp", 7, 0, 0, 0, 8'h50, 0);
    run("R6 push a", 4, 0, 0, 0, 8'h11, 0);
    run("R6 push b", 4, 0, 0, 0, 8'h22, 0);
    run("R6 push c", 4, 0, 0, 0, 8'h33, 0);
    run("R8 pop c", 5, 0, 0, 0, 0, 0);
    run("R8 pop b", 5, 0, 0, 0, 0, 0);
    run("R8 pop a", 5, 0, 0, 0, 0, 0);
    run("R10 swap back", 7, 0, 0, 0, 8'h00, 0);
    run("R7 wrap again", 4, 0, 0, 0, 8'h5C, 0);
    run("R8 pop wrap", 5, 0, 0, 0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule